// File: doc/BRIEF.md
# Buffered Fine-Resolution PWM Channel

This block is one PWM output channel with a 10-bit duty resolution, timed by one of several identical 8-bit period timers. Each timer counts a prescaled instruction cycle, four system clocks long, and reloads to zero after it has matched its period value. Two fine bits are appended below the 8-bit count to form a 10-bit time base. At a 1:1 prescale they are the clock phase inside the instruction cycle. Otherwise they are the upper two bits of the prescale count. The time base therefore advances once every `prescale` system clocks.

The duty value is written as an 8-bit upper byte plus a 2-bit lower field and is held in a staging register. The waveform only uses it after it has been copied into the active register, which happens at the start of the next period. A channel selector picks the timer that drives the channel. A freeze input stops all counting and holds the output. A low enable clears the channel.

Top module: `pwm10_unit`

## Requirements
- R1: The output period is (P+1)·4·K system clocks, where P is the selected timer's period value and K is the prescale ratio. The 2-bit prescale code maps 00→1, 01→4, 10 and 11→16.
- R2: At the clock edge after the timer's count equals P on its last prescaled clock, three things happen together: the count returns to zero, the output is set, and the staged duty is copied to the active duty.
- R3: With a staged duty of zero, the output is not set at the start of the period and stays low.
- R4: The 10-bit duty D is {duty_hi, duty_lo}: duty_hi holds bits 9..2 and duty_lo holds bits 1..0. The output stays high for D·K clocks of every period.
- R5: Writing the duty (duty_wr high for one clock) is allowed at any time. The new value first shapes the pulse of the period that starts after the write.
- R6: When D is at least 4·(P+1), the time base never reaches D. The output is never cleared and stays high.
- R7: tmr_sel picks timer i. Timer i uses period_all[8i+7:8i] and presc_all[2i+1:2i]. Select values of NUM_TMR or above pick timer 0.
- R8: While freeze is high, no timer advances and the output keeps its level. Counting resumes from the held state afterwards.
- R9: While enable is low, the output is low from the next clock onward, and the timers and the active duty are cleared. After enable rises, the first period stays low and the first pulse starts (P+1)·4·K clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel and timer run enable |
| freeze | input | 1 | Halts counting and holds the output |
| period_all | input | NUM_TMR·CNT_W | Period value of each timer, timer i in slice i |
| presc_all | input | NUM_TMR·2 | Prescale code of each timer, timer i in slice i |
| tmr_sel | input | SEL_W | Timer chosen as time base |
| duty_hi | input | CNT_W | Upper duty bits |
| duty_lo | input | 2 | Lower duty bits |
| duty_wr | input | 1 | Stores duty_hi/duty_lo into the staging register |
| pwm_out | output | 1 | PWM output |

## Verification
Several rules are checked on every cycle by the assertions. Each timer restarts from zero after a wrap. Count and prescale state hold under freeze, and the output is stable under freeze. A zero staged duty never produces a set. The active duty changes only at a wrap, and only to the staged value. A low enable forces the output and the active duty low. Other behaviour depends on the relation between the prescale, the period and the duty, so only the bench's measured pulses can show it. This covers the exact high time and period for each prescale ratio, a duty beyond the period, a write made mid-pulse, the timer choice including out-of-range selects, and the silent first period after enable.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
   localparam int PHASE_W = 2;   // clocks per instruction cycle = 2**PHASE_W
   localparam int PRE_W   = 4;   // prescale counter width, largest ratio 2**PRE_W

   typedef enum logic [1:0] {
      PS_DIV1   = 2'b00,
      PS_DIV4   = 2'b01,
      PS_DIV16  = 2'b10,
      PS_DIV16B = 2'b11
   } presc_e;

   // log2 of the prescale ratio
   function automatic int presc_shift(presc_e p);
      case (p)
         PS_DIV1: return 0;
         PS_DIV4: return 2;
         default: return 4;
      endcase
   endfunction
endpackage

// File: rtl/pwm10_timebase.sv
module pwm10_timebase
   import pwm10_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             frz,
   input  logic [CNT_W-1:0] period,
   input  presc_e           psel,
   output logic             wrap,
   output logic             step,
   output logic [CNT_W+1:0] tb_nxt
);
   localparam int SUB_W = PHASE_W + PRE_W;

   if (CNT_W < 2) begin : g_bad_w
      $error("pwm10_timebase: CNT_W must be at least 2");
   end

   logic [SUB_W-1:0] sub_q, sub_d, last_mask, step_mask;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             run, last;
   int               shamt;

   always_comb begin
      shamt     = presc_shift(psel);
      last_mask = SUB_W'((1 << (shamt + PHASE_W)) - 1);
      step_mask = SUB_W'((1 << shamt) - 1);
      run       = en && !frz;
      last      = (sub_q & last_mask) == last_mask;
      step      = run && ((sub_q & step_mask) == step_mask);
      wrap      = run && last && (cnt_q >= period);
      sub_d     = sub_q;
      cnt_d     = cnt_q;
      if (run) begin
         sub_d = last ? '0 : sub_q + 1'b1;
         if (last) cnt_d = (cnt_q >= period) ? '0 : cnt_q + 1'b1;
      end
      tb_nxt = {cnt_d, 2'((sub_d >> shamt) & SUB_W'(3))};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q <= '0;
         cnt_q <= '0;
      end else if (!en) begin
         sub_q <= '0;
         cnt_q <= '0;
      end else begin
         sub_q <= sub_d;
         cnt_q <= cnt_d;
      end
   end

   // R2: a wrap restarts the count and the prescale state
   a_r2_wrap_restart: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt_q == '0) && (sub_q == '0));

   // R8: frozen timer keeps its state
   a_r8_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en && frz) |=> ($stable(cnt_q) && $stable(sub_q)));
endmodule

// File: rtl/pwm10_wave.sv
module pwm10_wave #(
   parameter int TB_W = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            wr,
   input  logic [TB_W-1:0] wr_val,
   input  logic            wrap,
   input  logic            step,
   input  logic [TB_W-1:0] tb_nxt,
   output logic            pwm
);
   logic [TB_W-1:0] stage_q, act_q;
   logic            pwm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         act_q   <= '0;
         pwm_q   <= 1'b0;
      end else begin
         if (wr) stage_q <= wr_val;
         if (!en) begin
            act_q <= '0;
            pwm_q <= 1'b0;
         end else if (wrap) begin
            act_q <= stage_q;
            pwm_q <= (stage_q != '0);
         end else if (step && (tb_nxt == act_q)) begin
            pwm_q <= 1'b0;
         end
      end
   end

   assign pwm = pwm_q;

   // R3: zero staged duty never sets the output
   a_r3_zero_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      (en && wrap && (stage_q == '0)) |=> !pwm_q);

   // R5: active duty only moves at a period start
   a_r5_act_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !wrap) |=> $stable(act_q));

   // R2: period start copies the staged duty
   a_r2_act_load: assert property (@(posedge clk) disable iff (!rst_n)
      (en && wrap && !wr) |=> (act_q == $past(stage_q)));

   // R9: disabled channel is quiet
   a_r9_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!pwm_q && (act_q == '0)));
endmodule

// File: rtl/pwm10_unit.sv
module pwm10_unit
   import pwm10_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int NUM_TMR = 3,
   localparam int SEL_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     enable,
   input  logic                     freeze,
   input  logic [NUM_TMR*CNT_W-1:0] period_all,
   input  logic [NUM_TMR*2-1:0]     presc_all,
   input  logic [SEL_W-1:0]         tmr_sel,
   input  logic [CNT_W-1:0]         duty_hi,
   input  logic [1:0]               duty_lo,
   input  logic                     duty_wr,
   output logic                     pwm_out
);
   localparam int TB_W = CNT_W + PHASE_W;

   if (NUM_TMR < 1 || NUM_TMR > 8) begin : g_bad_n
      $error("pwm10_unit: NUM_TMR out of range");
   end

   logic [NUM_TMR-1:0] wrap_v, step_v;
   logic [TB_W-1:0]    tbn_v [NUM_TMR];
   logic               wrap_s, step_s;
   logic [TB_W-1:0]    tbn_s;

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
      pwm10_timebase #(.CNT_W(CNT_W)) u_tb (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (enable),
         .frz    (freeze),
         .period (period_all[i*CNT_W +: CNT_W]),
         .psel   (presc_e'(presc_all[i*2 +: 2])),
         .wrap   (wrap_v[i]),
         .step   (step_v[i]),
         .tb_nxt (tbn_v[i])
      );
   end

   always_comb begin
      wrap_s = wrap_v[0];
      step_s = step_v[0];
      tbn_s  = tbn_v[0];
      for (int i = 1; i < NUM_TMR; i++) begin
         if (int'(tmr_sel) == i) begin
            wrap_s = wrap_v[i];
            step_s = step_v[i];
            tbn_s  = tbn_v[i];
         end
      end
   end

   pwm10_wave #(.TB_W(TB_W)) u_wave (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (enable),
      .wr     (duty_wr),
      .wr_val ({duty_hi, duty_lo}),
      .wrap   (wrap_s),
      .step   (step_s),
      .tb_nxt (tbn_s),
      .pwm    (pwm_out)
   );

   // R8: output keeps its level while frozen
   a_r8_out_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && freeze) |=> $stable(pwm_out));
endmodule

// File: tb/pwm10_unit_test.sv
`timescale 1ns/1ps
module pwm10_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        freeze = 1'b0;
   logic [23:0] period_all = '0;
   logic [5:0]  presc_all = '0;
   logic [1:0]  tmr_sel = '0;
   logic [7:0]  duty_hi = '0;
   logic [1:0]  duty_lo = '0;
   logic        duty_wr = 1'b0;
   logic        pwm_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   pwm10_unit uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .freeze(freeze),
      .period_all(period_all), .presc_all(presc_all), .tmr_sel(tmr_sel),
      .duty_hi(duty_hi), .duty_lo(duty_lo), .duty_wr(duty_wr),
      .pwm_out(pwm_out)
   );

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_duty(logic [9:0] d);
      duty_hi = d[9:2];
      duty_lo = d[1:0];
      duty_wr = 1'b1;
      @(negedge clk);
      duty_wr = 1'b0;
   endtask

   // disable, reprogram all timers, stage a duty, re-enable
   task automatic restart(logic [23:0] per, logic [5:0] ps, logic [1:0] sel, logic [9:0] d);
      @(negedge clk);
      enable     = 1'b0;
      period_all = per;
      presc_all  = ps;
      tmr_sel    = sel;
      write_duty(d);
      @(negedge clk);
      enable = 1'b1;
   endtask

   task automatic wait_rise();
      int n = 0;
      while (pwm_out && n < 20000) begin @(negedge clk); n++; end
      while (!pwm_out && n < 20000) begin @(negedge clk); n++; end
   endtask

   task automatic measure(output int hi, output int per);
      bit low_seen = 0;
      hi = 0; per = 0;
      wait_rise();
      while (per < 20000) begin
         if (pwm_out && low_seen) break;
         if (!pwm_out) low_seen = 1;
         else hi++;
         per++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      chk("R9 reset low", int'(pwm_out), 0);
   endtask

   task automatic t_ratios();
      int h, p;
      restart({8'd0, 8'd0, 8'd3}, 6'b000000, 2'd0, 10'd5);
      measure(h, p);
      chk("R4 high ps1", h, 5);
      chk("R1 period ps1", p, 16);
      restart({8'd0, 8'd0, 8'd2}, 6'b000001, 2'd0, 10'd7);
      measure(h, p);
      chk("R4 high ps4", h, 28);
      chk("R1 period ps4", p, 48);
      restart({8'd0, 8'd0, 8'd1}, 6'b000010, 2'd0, 10'd3);
      measure(h, p);
      chk("R4 high ps16", h, 48);
      chk("R1 period ps16", p, 128);
      restart({8'd0, 8'd0, 8'd1}, 6'b000011, 2'd0, 10'd2);
      measure(h, p);
      chk("R1 period code3", p, 128);
   endtask

   task automatic t_zero();
      int highs = 0;
      restart({8'd0, 8'd0, 8'd3}, 6'b000000, 2'd0, 10'd0);
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         if (pwm_out) highs++;
      end
      chk("R3 zero duty stays low", highs, 0);
   endtask

   task automatic t_over();
      int lows = 0;
      restart({8'd0, 8'd0, 8'd3}, 6'b000000, 2'd0, 10'd100);
      wait_rise();
      for (int i = 0; i < 48; i++) begin
         @(negedge clk);
         if (!pwm_out) lows++;
      end
      chk("R6 oversize duty never clears", lows, 0);
      restart({8'd0, 8'd0, 8'd3}, 6'b000000, 2'd0, 10'd16);
      wait_rise();
      lows = 0;
      for (int i = 0; i < 48; i++) begin
         @(negedge clk);
         if (!pwm_out) lows++;
      end
      chk("R6 duty equal 4(P+1)", lows, 0);
   endtask

   task automatic t_midwrite();
      int h = 1, p;
      restart({8'd0, 8'd0, 8'd3}, 6'b000000, 2'd0, 10'd5);
      wait_rise();
      write_duty(10'd10);
      while (pwm_out && h < 100) begin h++; @(negedge clk); end
      chk("R5 current pulse unchanged", h, 5);
      measure(h, p);
      chk("R5 next pulse uses new duty", h, 10);
      chk("R1 period after write", p, 16);
   endtask

   task automatic t_freeze();
      int h = 1;
      restart({8'd0, 8'd0, 8'd3}, 6'b000000, 2'd0, 10'd5);
      wait_rise();
      @(negedge clk);
      h++;
      freeze = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (pwm_out) h++;
      end
      freeze = 1'b0;
      forever begin
         @(negedge clk);
         if (!pwm_out || h > 200) break;
         h++;
      end
      chk("R8 freeze stretches pulse", h, 25);
   endtask

   task automatic t_select();
      int h, p;
      restart({8'd1, 8'd7, 8'd3}, 6'b010000, 2'd1, 10'd6);
      measure(h, p);
      chk("R7 sel1 high", h, 6);
      chk("R7 sel1 period", p, 32);
      restart({8'd1, 8'd7, 8'd3}, 6'b010000, 2'd2, 10'd6);
      measure(h, p);
      chk("R7 sel2 high", h, 24);
      chk("R7 sel2 period", p, 32);
      restart({8'd1, 8'd7, 8'd3}, 6'b010000, 2'd3, 10'd6);
      measure(h, p);
      chk("R7 sel3 falls back to timer0", p, 16);
   endtask

   task automatic t_enable();
      int highs = 0, lows = 0;
      restart({8'd0, 8'd0, 8'd3}, 6'b000000, 2'd0, 10'd12);
      wait_rise();
      enable = 1'b0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (pwm_out) highs++;
      end
      chk("R9 disabled output low", highs, 0);
      enable = 1'b1;
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         if (!pwm_out) lows++;
      end
      chk("R9 first period silent", lows, 15);
      @(negedge clk);
      chk("R2 set at first wrap", int'(pwm_out), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_ratios();
      t_zero();
      t_over();
      t_midwrite();
      t_freeze();
      t_select();
      t_enable();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      #750000;
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule